// File: doc/BRIEF.md
# Shared-RAM Serial Command Formatter

The block holds a short command, stored as 4-bit characters in a small RAM, and sends it out as a serial bit stream at a slow bit rate. While the block is idle, a host processor owns the RAM: it presents an address, writes characters and reads them back. A one-cycle start request carries a command code. The code is decoded into the number of data bits to send: code `c` selects characters 0 through `c`, which is `4*(c+1)` bits. The RAM address multiplexer then gives RAM addressing to the internal bit index. The cycle opens with one dummy bit of value 0. After it, every character is sent most significant bit first. A bit strobe output marks the bit period of every bit sent, and this strobe is the gated bit clock.

A format select, latched at start, chooses the destination. In display format the stream drives both the display line and the receiver line. In computer format it drives only the computer line. The bit rate comes from a divider enable, `DIV` system clocks per bit; no derived clock is used. The shutdown takes two steps. When the next-to-last bit ends, the sequencer enters an armed state, which is the load latch. When the last bit ends, it passes through a one-cycle release state that hands RAM addressing back to the host.

Sequencer states and transitions:
- IDLE goes to DUMMY on a start request.
- DUMMY goes to DATA at the end of its bit.
- DATA stays in DATA while bits remain.
- DATA goes to LAST when the next-to-last bit ends.
- LAST goes to RELEASE when the last bit ends.
- RELEASE goes to IDLE unconditionally.

Top module: `serial_cmd_formatter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy` is 0, `bit_strobe` is 0 and all three serial outputs are 0.
- R2: A start request sampled while idle raises `busy` in the next cycle. `busy` then stays high for exactly `(4*(c+1)+1)*DIV+1` cycles: the DUMMY, DATA and LAST bit periods plus one RELEASE cycle.
- R3: A command code `c` gives exactly `4*(c+1)+1` bit strobes per cycle: one dummy bit of value 0, then `4*(c+1)` data bits.
- R4: Data bit `i`, counting from 0, is bit `3-(i mod 4)` of the RAM word at address `i/4`. Each character therefore goes out most significant bit first, at increasing addresses.
- R5: Each bit lasts `DIV` system clocks. `bit_strobe` is high only in the last clock of each bit period. The first strobe comes in the `DIV`-th cycle with `busy` high, and consecutive strobes are exactly `DIV` cycles apart.
- R6: With format select 0 latched, the stream appears on `disp_dout` and `rcvr_dout` and `host_dout` stays 0. With format select 1 latched, the stream appears on `host_dout` and the other two stay 0.
- R7: A start request while `busy` is high is ignored. It changes neither the length, the data nor the routing of the current cycle.
- R8: A write while idle stores `cpu_wdata` at `cpu_addr`. While idle, `cpu_rdata` shows the word at `cpu_addr`. A write while `busy` is high is ignored.
- R9: While `busy` is low, `bit_strobe` and all serial outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 4 | Host RAM address |
| cpu_wdata | input | 4 | Host write character |
| cpu_we | input | 1 | Host write enable |
| cpu_rdata | output | 4 | RAM word at the current multiplexed address |
| start | input | 1 | One-cycle transfer request |
| cmd_code | input | 3 | Command code; selects the bit count |
| fmt_host | input | 1 | Format select: 1 selects the computer output |
| busy | output | 1 | High from start until addressing returns to the host |
| bit_strobe | output | 1 | Gated bit clock enable, one pulse per bit |
| disp_dout | output | 1 | Serial data to the display |
| rcvr_dout | output | 1 | Serial data to the receiver |
| host_dout | output | 1 | Serial data to the computer |

## Verification
The assertions assume the following about the inputs:
- `DIV` is at least 2.
- The host does not expect to read the RAM through `cpu_rdata` while `busy` is high.

Under these assumptions, strobes never come in back-to-back cycles, and routing stays exclusive.

The stimulus keeps within these assumptions. It drives inputs only on falling edges. It reads the RAM back only while idle. It issues its extra start requests and writes only in the middle of a cycle, so it can show that they are ignored.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_DATA,
        ST_LAST,
        ST_RELEASE
    } fmt_state_e;
endpackage

// File: rtl/fmt_bit_timer.sv
module fmt_bit_timer #(
    parameter int DIV = 15385
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV + 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/fmt_char_ram.sv
module fmt_char_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ser_sel,
    input  logic [ADDR_W-1:0] ser_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] mux_addr;

    assign mux_addr = ser_sel ? ser_addr : cpu_addr;
    assign rd_data  = mem[mux_addr];

    always_ff @(posedge clk) begin
        if (wr_en && !ser_sel) begin
            mem[cpu_addr] <= wdata;
        end
    end
endmodule

// File: rtl/fmt_sequencer.sv
module fmt_sequencer
    import fmt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    parameter int CMD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              fmt_in,
    input  logic              tick,
    input  logic [DATA_W-1:0] rd_word,
    output logic              busy,
    output logic              run,
    output logic              ser_sel,
    output logic [ADDR_W-1:0] ser_addr,
    output logic              stream_bit,
    output logic              strobe,
    output logic              fmt_q
);
    localparam int MAX_BITS = (1 << CMD_W) * DATA_W;
    localparam int BIT_W    = $clog2(MAX_BITS) + 1;
    localparam int POS_W    = $clog2(DATA_W);

    fmt_state_e       state_q, state_d;
    logic [BIT_W-1:0] idx_q, idx_d;
    logic [BIT_W-1:0] nbits_q, nbits_d;
    logic             fmt_d;
    logic [POS_W-1:0] msb_pos;

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            nbits_q <= '0;
            fmt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            nbits_q <= nbits_d;
            fmt_q   <= fmt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        nbits_d = nbits_q;
        fmt_d   = fmt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_DUMMY;
                    idx_d   = '0;
                    nbits_d = BIT_W'((32'(cmd_code) + 32'd1) * DATA_W);
                    fmt_d   = fmt_in;
                end
            end
            ST_DUMMY: begin
                if (tick) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (tick) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == nbits_q - BIT_W'(2)) state_d = ST_LAST;
                end
            end
            ST_LAST: begin
                if (tick) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign msb_pos  = POS_W'(DATA_W - 1) - idx_q[POS_W-1:0];
    assign ser_addr = ADDR_W'(idx_q >> POS_W);

    // Output logic
    always_comb begin
        busy       = 1'b0;
        run        = 1'b0;
        ser_sel    = 1'b0;
        stream_bit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_DUMMY: begin
                busy    = 1'b1;
                run     = 1'b1;
                ser_sel = 1'b1;
            end
            ST_DATA, ST_LAST: begin
                busy       = 1'b1;
                run        = 1'b1;
                ser_sel    = 1'b1;
                stream_bit = rd_word[msb_pos];
            end
            ST_RELEASE: begin
                busy    = 1'b1;
                ser_sel = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign strobe = run && tick;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(nbits_q) && $stable(fmt_q))); // R7
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (idx_q < nbits_q)); // R3
    AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE) |=> (state_q == ST_IDLE)); // R2
endmodule

// File: rtl/serial_cmd_formatter.sv
module serial_cmd_formatter #(
    parameter int DIV    = 15385,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    parameter int CMD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              fmt_host,
    output logic              busy,
    output logic              bit_strobe,
    output logic              disp_dout,
    output logic              rcvr_dout,
    output logic              host_dout
);
    logic              tick;
    logic              run;
    logic              ser_sel;
    logic [ADDR_W-1:0] ser_addr;
    logic              stream_bit;
    logic              fmt_q;

    fmt_bit_timer #(.DIV(DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    fmt_char_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .wr_en   (cpu_we),
        .cpu_addr(cpu_addr),
        .wdata   (cpu_wdata),
        .ser_sel (ser_sel),
        .ser_addr(ser_addr),
        .rd_data (cpu_rdata)
    );

    fmt_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_code  (cmd_code),
        .fmt_in    (fmt_host),
        .tick      (tick),
        .rd_word   (cpu_rdata),
        .busy      (busy),
        .run       (run),
        .ser_sel   (ser_sel),
        .ser_addr  (ser_addr),
        .stream_bit(stream_bit),
        .strobe    (bit_strobe),
        .fmt_q     (fmt_q)
    );

    assign disp_dout = stream_bit && !fmt_q;
    assign rcvr_dout = stream_bit && !fmt_q;
    assign host_dout = stream_bit && fmt_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bit_strobe || disp_dout || rcvr_dout || host_dout)); // R9
    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        host_dout |-> !(disp_dout || rcvr_dout)); // R6
endmodule

// File: tb/serial_cmd_formatter_tb_top.sv
module serial_cmd_formatter_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [3:0] cpu_wdata = '0;
    logic       cpu_we = 1'b0;
    logic [3:0] cpu_rdata;
    logic       start = 1'b0;
    logic [2:0] cmd_code = '0;
    logic       fmt_host = 1'b0;
    logic       busy, bit_strobe, disp_dout, rcvr_dout, host_dout;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    int  idle_bad = 0;
    int  cyc = 0;
    int  last_tick = -1;
    bit  prev_busy = 1'b0;
    logic [3:0] model [16];
    logic [1:0] exp_q [$];

    always #5 clk = ~clk;

    serial_cmd_formatter #(.DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_rdata(cpu_rdata), .start(start), .cmd_code(cmd_code),
        .fmt_host(fmt_host), .busy(busy), .bit_strobe(bit_strobe),
        .disp_dout(disp_dout), .rcvr_dout(rcvr_dout), .host_dout(host_dout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected bits at each strobe and checks bit spacing
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (busy && !prev_busy) last_tick = cyc - 1;
            if (!busy) begin
                last_tick = -1;
                if (bit_strobe || disp_dout || rcvr_dout || host_dout) idle_bad++;
            end
            if (bit_strobe) begin
                chk(last_tick >= 0 && (cyc - last_tick) == DIV, "R5 strobe spacing",
                    cyc - last_tick, DIV);
                last_tick = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 extra bit", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    if (e[1]) begin
                        chk(host_dout == e[0] && !disp_dout && !rcvr_dout,
                            "R4/R6 host stream", {disp_dout, rcvr_dout, host_dout}, {2'b00, e[0]});
                    end else begin
                        chk(disp_dout == e[0] && rcvr_dout == e[0] && !host_dout,
                            "R4/R6 display stream", {disp_dout, rcvr_dout, host_dout}, {e[0], e[0], 1'b0});
                    end
                end
            end
            prev_busy = busy;
        end
    end

    task automatic wr(input int a, input logic [3:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 4'(a); cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        model[a] = d;
    endtask

    task automatic run_cmd(input int c, input bit f, input bit meddle);
        int nb, len;
        nb = 4 * (c + 1);
        exp_q.push_back({f, 1'b0});
        for (int k = 0; k <= c; k++)
            for (int b = 3; b >= 0; b--)
                exp_q.push_back({f, model[k][b]});
        @(negedge clk);
        start = 1'b1; cmd_code = 3'(c); fmt_host = f;
        @(negedge clk);
        start = 1'b0; cmd_code = 3'(7 - c); fmt_host = !f;
        chk(busy == 1'b1, "R2 busy rises", busy, 1);
        len = 0;
        while (busy) begin
            len++;
            if (meddle) begin
                if (len == 10) begin start = 1'b1; cmd_code = 3'd7; fmt_host = !f; end
                if (len == 11) start = 1'b0;
                if (len == 14) begin cpu_we = 1'b1; cpu_addr = 4'd0; cpu_wdata = ~model[0]; end
                if (len == 15) cpu_we = 1'b0;
            end
            @(negedge clk);
        end
        chk(len == (nb + 1) * DIV + 1, "R2 busy length", len, (nb + 1) * DIV + 1);
        chk(exp_q.size() == 0, meddle ? "R7 stream length with extra start" : "R3 stream length",
            exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !bit_strobe && !disp_dout && !rcvr_dout && !host_dout,
            "R1 reset outputs", {busy, bit_strobe, disp_dout, rcvr_dout, host_dout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bit_strobe, "R1 after reset", {busy, bit_strobe}, 0);

        wr(0, 4'hA); wr(1, 4'h5); wr(2, 4'hF); wr(3, 4'h0);
        wr(4, 4'hC); wr(5, 4'h3); wr(6, 4'h9); wr(7, 4'h6);
        cpu_addr = 4'd5;
        @(negedge clk);
        chk(cpu_rdata == 4'h3, "R8 idle readback", cpu_rdata, 3);

        run_cmd(0, 1'b0, 1'b0);
        run_cmd(7, 1'b1, 1'b0);
        run_cmd(3, 1'b0, 1'b1);
        cpu_addr = 4'd0;
        @(negedge clk);
        chk(cpu_rdata == model[0], "R8 busy write ignored", cpu_rdata, model[0]);
        run_cmd(1, 1'b1, 1'b0);

        wr(0, 4'h1); wr(1, 4'hE); wr(2, 4'h7);
        cpu_addr = 4'd1;
        @(negedge clk);
        chk(cpu_rdata == 4'hE, "R8 idle write", cpu_rdata, 14);
        run_cmd(2, 1'b0, 1'b0);

        repeat (5) @(negedge clk);
        chk(idle_bad == 0, "R9 idle quiet", idle_bad, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule